// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block watches over a programmable clock generator whose output frequency software may raise. Once armed, it counts whole seconds down from a programmed timeout. The seconds are derived from the reference clock by a prescaler. Software keeps it alive either with a service pulse or with any write to the configuration registers. If neither comes in time, the block overrides the generator's frequency selection with a safe code held in the control register and raises a sticky status flag. The override stays in force until software disarms the watchdog.

The block also contains the source selector. In normal operation the control register's top bit chooses between two sources: the hardware (strap or register-0) frequency selection, and the directly programmed divider-ratio registers. While the override is active, the hardware path is always chosen and the select value is replaced by the safe code.

Top module: `ofb_watchdog`

## Requirements
- R1: After reset the status flag is 0, no override is active, and `sel_o` equals `hw_sel_i`.
- R2: Without an override, `use_div_o` equals control bit 7 (0 = hardware/register-0 source, 1 = divider registers) and `sel_o` follows `hw_sel_i` combinationally.
- R3: When control bit 6 (enable) is 1 and nothing reloads the counter, the override and the status flag appear after N·T clock edges counted from the reload edge. Here N is the count register value (N ≥ 1) and T is the number of reference cycles per second. While the override is active, `sel_o` equals control bits 4:0, `use_div_o` is 0 and `wd_stat_o` is 1.
- R4: A cycle with `kick_i` or `cfg_wr_i` high reloads the seconds counter from the count register and restarts the current second, so the timeout is measured again from that edge.
- R5: While control bit 6 is 0, the counter is held at its reload value and no override occurs. Clearing bit 6 ends an active override at the next edge.
- R6: The status flag is sticky. It is cleared only by a cycle with `cfg_wr_i` high and control bit 5 at 0. A write with bit 5 at 1 leaves it set. Clearing the flag does not end the override.
- R7: A count register value of 0 trips at the end of the first second, T edges after the reload edge.
- R8: A change of the count register while armed takes effect only at the next reload; the running countdown keeps its schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_reg_i | input | CNT_W | Timeout in seconds |
| ctl_reg_i | input | 8 | Control: [7] source, [6] enable, [5] status (write 0 clears), [4:0] safe code |
| cfg_wr_i | input | 1 | Pulse on any configuration register write |
| kick_i | input | 1 | Service pulse |
| hw_sel_i | input | 5 | Hardware/register-0 frequency selection |
| sel_o | output | 5 | Effective frequency selection |
| use_div_o | output | 1 | 1 = divider registers drive the frequency |
| wd_stat_o | output | 1 | Sticky timeout status |

## Verification
The select and source outputs follow their inputs within the same cycle. The override and status respond at the first clock edge after the deciding event: a trip, a disarm or a clearing write. A trip falls exactly N·T edges after the reload edge, with T shortened to 8 in the bench. A behavioural model updates at every rising edge from inputs that change 2 ns after it. Outputs are compared with the model at every falling edge. Directed checks sample one cycle before and one cycle at each predicted trip edge, so an off-by-one in either direction is caught.

// File: rtl/ofb_pkg.sv
package ofb_pkg;

    localparam int SEL_W = 5;
    localparam int CTL_W = 8;

    typedef struct packed {
        logic             src_div;
        logic             wd_en;
        logic             wd_stat;
        logic [SEL_W-1:0] safe_sel;
    } ofb_ctl_t;

    typedef enum logic {
        SRC_HW  = 1'b0,
        SRC_DIV = 1'b1
    } ofb_src_e;

    function automatic ofb_ctl_t ofb_unpack(input logic [CTL_W-1:0] raw);
        return ofb_ctl_t'(raw);
    endfunction

    function automatic ofb_src_e ofb_src(input ofb_ctl_t c, input logic forced);
        return (forced || !c.src_div) ? SRC_HW : SRC_DIV;
    endfunction

endpackage

// File: rtl/ofb_prescaler.sv
module ofb_prescaler #(
    parameter int TPS = 14318180
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic hold_i,
    output logic tick_o
);
    localparam int PW = (TPS > 2) ? $clog2(TPS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TPS - 1);

    logic [PW-1:0] pre_q;

    assign tick_o = !hold_i && (pre_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    p_pre_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        pre_q <= LAST);

    p_hold_clears_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> pre_q == '0);

endmodule

// File: rtl/ofb_countdown.sv
module ofb_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             arm_i,
    input  logic             reload_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             trip_o
);
    logic [CNT_W-1:0] sec_q;

    assign trip_o = tick_i && (sec_q <= CNT_W'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i || !arm_i || reload_i) begin
            sec_q <= load_i;
        end else if (tick_i && sec_q != '0) begin
            sec_q <= sec_q - 1'b1;
        end
    end

    p_reload_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        reload_i |=> sec_q == $past(load_i));

    p_no_rise_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (arm_i && !reload_i) |=> sec_q <= $past(sec_q));

    p_held_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !arm_i |-> !trip_o || !tick_i);

endmodule

// File: rtl/ofb_guard.sv
module ofb_guard (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_i,
    input  logic trip_i,
    input  logic clr_i,
    output logic ovr_o,
    output logic stat_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ovr_o  <= 1'b0;
            stat_o <= 1'b0;
        end else begin
            if (!arm_i) begin
                ovr_o <= 1'b0;
            end else if (trip_i) begin
                ovr_o <= 1'b1;
            end
            if (trip_i) begin
                stat_o <= 1'b1;
            end else if (clr_i) begin
                stat_o <= 1'b0;
            end
        end
    end

    p_trip_flags_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (trip_i && arm_i) |=> ovr_o && stat_o);

    p_ovr_cause_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ovr_o) |-> $past(trip_i));

    p_disarm_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !arm_i |=> !ovr_o);

    p_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (stat_o && !clr_i) |=> stat_o);

endmodule

// File: rtl/ofb_watchdog.sv
module ofb_watchdog
    import ofb_pkg::*;
#(
    parameter int TPS   = 14318180,
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] cnt_reg_i,
    input  logic [CTL_W-1:0] ctl_reg_i,
    input  logic             cfg_wr_i,
    input  logic             kick_i,
    input  logic [SEL_W-1:0] hw_sel_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             use_div_o,
    output logic             wd_stat_o
);
    ofb_ctl_t ctl;
    ofb_src_e src;
    logic     reload;
    logic     ovr;
    logic     tick;
    logic     trip;
    logic     clr;

    assign ctl    = ofb_unpack(ctl_reg_i);
    assign reload = kick_i || cfg_wr_i;
    assign clr    = cfg_wr_i && !ctl.wd_stat;

    ofb_prescaler #(.TPS(TPS)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .hold_i (!ctl.wd_en || reload || ovr),
        .tick_o (tick)
    );

    ofb_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .arm_i    (ctl.wd_en),
        .reload_i (reload),
        .tick_i   (tick),
        .load_i   (cnt_reg_i),
        .trip_o   (trip)
    );

    ofb_guard u_grd (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .arm_i  (ctl.wd_en),
        .trip_i (trip),
        .clr_i  (clr),
        .ovr_o  (ovr),
        .stat_o (wd_stat_o)
    );

    assign src       = ofb_src(ctl, ovr);
    assign use_div_o = (src == SRC_DIV);
    assign sel_o     = ovr ? ctl.safe_sel : hw_sel_i;

    p_forced_hw_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wd_stat_o && $rose(ovr)) |-> !use_div_o && sel_o == ctl.safe_sel);

    p_reset_clean_r1: assert property (@(posedge clk_i)
        $past(rst_i) |-> !wd_stat_o && !ovr);

endmodule

// File: tb/sim_ofb_watchdog.sv
module sim_ofb_watchdog;
    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cnt_reg = 8'h10;
    logic [7:0] ctl_reg = 8'h00;
    logic       cfg_wr = 1'b0;
    logic       kick = 1'b0;
    logic [4:0] hw_sel = 5'h03;
    logic [4:0] sel;
    logic       use_div;
    logic       stat;

    int n_run = 0;
    int n_fail = 0;
    string phase = "R1";

    int m_pre, m_sec;
    bit m_ovr, m_stat;

    always #4 clk = ~clk;

    ofb_watchdog #(.TPS(T), .CNT_W(8)) u0 (
        .clk_i(clk), .rst_i(rst), .cnt_reg_i(cnt_reg), .ctl_reg_i(ctl_reg),
        .cfg_wr_i(cfg_wr), .kick_i(kick), .hw_sel_i(hw_sel),
        .sel_o(sel), .use_div_o(use_div), .wd_stat_o(stat)
    );

    // behavioural reference: seconds countdown from the requirements
    always @(posedge clk) begin
        bit en, rl, tk;
        en = ctl_reg[6];
        rl = kick || cfg_wr;
        if (rst) begin
            m_pre = 0; m_sec = cnt_reg; m_ovr = 0; m_stat = 0;
        end else begin
            tk = en && !rl && !m_ovr && (m_pre == T - 1);
            if (!en || rl || m_ovr) m_pre = 0;
            else m_pre = (m_pre == T - 1) ? 0 : m_pre + 1;
            if (tk && m_sec <= 1) begin
                m_ovr = 1; m_stat = 1;
            end else if (cfg_wr && !ctl_reg[5]) begin
                m_stat = 0;
            end
            if (!en) m_ovr = 0;
            if (!en || rl) m_sec = cnt_reg;
            else if (tk && m_sec > 0) m_sec = m_sec - 1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [4:0] e_sel;
            logic e_div;
            e_sel = m_ovr ? ctl_reg[4:0] : hw_sel;
            e_div = m_ovr ? 1'b0 : ctl_reg[7];
            n_run++;
            if (sel !== e_sel || use_div !== e_div || stat !== m_stat) begin
                n_fail++;
                $display("FAIL %s model: sel=%h div=%b stat=%b expected sel=%h div=%b stat=%b",
                         phase, sel, use_div, stat, e_sel, e_div, m_stat);
            end
        end
    end

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] c);
        @(posedge clk); #2 ctl_reg = c; cfg_wr = 1'b1;
        @(posedge clk); #2 cfg_wr = 1'b0;
    endtask

    task automatic kick_once();
        @(posedge clk); #2 kick = 1'b1;
        @(posedge clk); #2 kick = 1'b0;
    endtask

    task automatic look(input string req, input logic [6:0] exp);
        @(negedge clk); chk(req, {sel, use_div, stat}, exp);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset state
        look("R1", {5'h03, 1'b0, 1'b0});
        // R2 source selection and pass-through
        phase = "R2";
        @(posedge clk); #2 ctl_reg = 8'h80; hw_sel = 5'h1A;
        look("R2", {5'h1A, 1'b1, 1'b0});
        #1 hw_sel = 5'h05; #1;
        chk("R2", {sel, use_div, stat}, {5'h05, 1'b1, 1'b0});
        // R3 trip after N*T edges, safe code 0B
        phase = "R3";
        cnt_reg = 8'd3;
        wr(8'hCB);
        repeat (23) @(posedge clk);
        look("R3", {5'h05, 1'b1, 1'b0});
        @(posedge clk);
        look("R3", {5'h0B, 1'b0, 1'b1});
        // R6 sticky status
        phase = "R6";
        wr(8'hEB);
        look("R6", {5'h0B, 1'b0, 1'b1});
        wr(8'hCB);
        look("R6", {5'h0B, 1'b0, 1'b0});
        // R5 disarm ends override, disabled never trips
        phase = "R5";
        cnt_reg = 8'd1;
        wr(8'h8B);
        look("R5", {5'h05, 1'b1, 1'b0});
        repeat (100) @(posedge clk);
        look("R5", {5'h05, 1'b1, 1'b0});
        // R4 kick restarts the timeout
        phase = "R4";
        cnt_reg = 8'd2;
        wr(8'h4B);
        repeat (9) @(posedge clk);
        #2 kick = 1'b1;
        @(posedge clk); #2 kick = 1'b0;
        repeat (15) @(posedge clk);
        look("R4", {5'h05, 1'b0, 1'b0});
        @(posedge clk);
        look("R4", {5'h0B, 1'b0, 1'b1});
        // R7 zero count trips after one second
        phase = "R7";
        wr(8'h0B);
        cnt_reg = 8'd0;
        wr(8'h4B);
        repeat (T - 1) @(posedge clk);
        look("R7", {5'h05, 1'b0, 1'b0});
        @(posedge clk);
        look("R7", {5'h0B, 1'b0, 1'b1});
        // R8 count change without reload keeps schedule
        phase = "R8";
        wr(8'h0B);
        cnt_reg = 8'd2;
        wr(8'h4B);
        repeat (3) @(posedge clk);
        #2 cnt_reg = 8'd5;
        repeat (12) @(posedge clk);
        look("R8", {5'h05, 1'b0, 1'b0});
        @(posedge clk);
        look("R8", {5'h0B, 1'b0, 1'b1});
        kick_once();
        look("R8", {5'h0B, 1'b0, 1'b1});
        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule